// File: doc/BRIEF.md
# SEC-DED Error Detection and Correction Unit

This unit sits between a 32-bit data bus and a memory that keeps 7 check bits per word in a separate array. A write computes the check bits from the incoming word and passes the word through unchanged, so both can be stored side by side. A read takes a stored word and its stored check bits and recomputes the check bits to form a syndrome. It then corrects any single flipped bit of the 39-bit codeword and reports on two separate lines whether the error was correctable or not.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream. A request moves forward on every edge where `in_valid` and `in_ready` are both high. A result is held on the output until `out_ready` is sampled high. While a result waits with `out_ready` low, the whole two-stage pipeline freezes and `in_ready` goes low. Nothing is dropped and nothing is duplicated.

The error flags are known one stage before the corrected word. They appear first on the `det_*` pins and travel on with the word to the `out_*` pins. A diagnostic override replaces the computed check bits on writes, so that known error patterns can be stored and read back.

Top module: `edc_unit`

## Requirements
- R1: A write (`in_write`=1) delivers `out_data` equal to `in_data`. It delivers `out_check` as follows. Number the codeword positions from 1. Data bit j sits at the (j+1)-th position that is not a power of two, so bit 0 is at 3 and bit 31 is at 38. Check bit i (i=0..5) is the XOR of all data bits whose position has bit i set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5.
- R2: A write raises neither the single-error nor the multi-error flag.
- R3: A read of an intact codeword raises no flag, and `out_data` equals `in_data`.
- R4: A read with exactly one data bit flipped raises the single-error flag only, and `out_data` is the original word.
- R5: A read with exactly one check bit flipped (including check bit 6) raises the single-error flag only, and `out_data` equals `in_data` unchanged.
- R6: A read with any two bits of the 39-bit codeword flipped raises the multi-error flag only, and `out_data` equals `in_data` with no correction.
- R7: A read whose overall parity is odd and whose 6-bit syndrome names a position above 38 raises the multi-error flag only.
- R8: The flags of a request accepted at edge k appear on `det_*` with `det_valid` after edge k. When the output is not stalled, the word appears on `out_*` with `out_valid` after edge k+1.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data`/`out_check` hold their values. Requests then resume in order.
- R10: On a write with `diag_en`=1, `out_check` equals `diag_check`. On a read, `diag_en` has no effect, and `out_check` always returns `in_check`.
- R11: After reset, `det_valid`, `out_valid` and all flags are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_write | input | 1 | 1 = write (encode), 0 = read (check and correct) |
| in_data | input | 32 | Data word from bus or memory |
| in_check | input | 7 | Stored check bits (reads) |
| diag_en | input | 1 | Replace computed check bits on writes |
| diag_check | input | 7 | Check bits used when diag_en is set |
| det_valid | output | 1 | Early flags valid |
| det_single | output | 1 | Early correctable-error flag |
| det_multi | output | 1 | Early uncorrectable-error flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_data | output | 32 | Corrected (read) or passed (write) data |
| out_check | output | 7 | Check bits to store (write) or as received (read) |
| out_single | output | 1 | Correctable-error flag with the result |
| out_multi | output | 1 | Uncorrectable-error flag with the result |

## Verification
The flags of a request are due in the cycle after its acceptance edge, and the data one cycle later. The bench issues one request at a time with `out_ready` high. It checks `det_*` at the falling edge after acceptance and `out_*` at the next falling edge. It sweeps every single-bit and every double-bit flip of the codeword over several data words, and its expected check bits come from an arithmetic XOR of positions. In the stall scenario the cycle counts are worked out edge by edge, and each value is sampled at the falling edge where it is due.

// File: rtl/edc_pkg.sv
package edc_pkg;
  // Number of position-coded check bits needed for dw data bits
  function automatic int ham_bits(int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Codeword position (1-based) of data bit j: j-th non power of two
  function automatic int data_pos(int j);
    int cnt;
    cnt = 0;
    for (int pos = 3; pos < 1024; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (cnt == j) return pos;
        cnt++;
      end
    end
    return 0;
  endfunction

  // Data bits covered by check bit i
  function automatic logic [255:0] cover_mask(int i, int dw);
    logic [255:0] m;
    m = '0;
    for (int j = 0; j < dw; j++) m[j] = ((data_pos(j) >> i) & 1) != 0;
    return m;
  endfunction
endpackage

// File: rtl/edc_encoder.sv
module edc_encoder #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = 6
) (
  input  logic [DATA_W-1:0] data,
  output logic [HAM_W:0]    chk
);
  for (genvar i = 0; i < HAM_W; i++) begin : g_par
    localparam logic [255:0] MASK = edc_pkg::cover_mask(i, DATA_W);
    assign chk[i] = ^(data & MASK[DATA_W-1:0]);
  end
  assign chk[HAM_W] = (^data) ^ (^chk[HAM_W-1:0]);
endmodule

// File: rtl/edc_syndrome.sv
module edc_syndrome #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = 6
) (
  input  logic [DATA_W-1:0] data,
  input  logic [HAM_W:0]    chk_in,
  output logic [HAM_W:0]    chk_calc,
  output logic [HAM_W-1:0]  syn,
  output logic              single,
  output logic              multi
);
  localparam logic [HAM_W-1:0] TOP_POS = HAM_W'(DATA_W + HAM_W);

  logic odd;
  logic in_range;

  edc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .data (data),
    .chk  (chk_calc)
  );

  assign syn      = chk_in[HAM_W-1:0] ^ chk_calc[HAM_W-1:0];
  assign odd      = (^data) ^ (^chk_in);
  assign in_range = (syn <= TOP_POS);
  assign single   = odd && in_range;
  assign multi    = (odd && !in_range) || (!odd && (syn != '0));
endmodule

// File: rtl/edc_corrector.sv
module edc_corrector #(
  parameter int DATA_W = 32,
  parameter int HAM_W  = 6
) (
  input  logic [DATA_W-1:0] data,
  input  logic [HAM_W-1:0]  syn,
  input  logic              single,
  output logic [DATA_W-1:0] fixed
);
  logic [DATA_W-1:0] flip;
  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    localparam logic [HAM_W-1:0] POS = HAM_W'(edc_pkg::data_pos(j));
    assign flip[j] = single && (syn == POS);
  end
  assign fixed = data ^ flip;
endmodule

// File: rtl/edc_unit.sv
module edc_unit #(
  parameter int DATA_W = 32,
  localparam int HAM_W = edc_pkg::ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHK_W-1:0]  in_check,
  input  logic              diag_en,
  input  logic [CHK_W-1:0]  diag_check,
  output logic              det_valid,
  output logic              det_single,
  output logic              det_multi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_check,
  output logic              out_single,
  output logic              out_multi
);
  logic              adv;
  logic [CHK_W-1:0]  calc;
  logic [HAM_W-1:0]  syn_c;
  logic              sgl_c, mul_c;

  logic              s1_valid, s1_single, s1_multi;
  logic [DATA_W-1:0] s1_data;
  logic [CHK_W-1:0]  s1_check;
  logic [HAM_W-1:0]  s1_syn;
  logic [DATA_W-1:0] fixed;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  edc_syndrome #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_syn (
    .data     (in_data),
    .chk_in   (in_check),
    .chk_calc (calc),
    .syn      (syn_c),
    .single   (sgl_c),
    .multi    (mul_c)
  );

  // Stage 1: detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_single <= 1'b0;
      s1_multi  <= 1'b0;
      s1_data   <= '0;
      s1_check  <= '0;
      s1_syn    <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_data  <= in_data;
      if (in_write) begin
        s1_check  <= diag_en ? diag_check : calc;
        s1_syn    <= '0;
        s1_single <= 1'b0;
        s1_multi  <= 1'b0;
      end else begin
        s1_check  <= in_check;
        s1_syn    <= syn_c;
        s1_single <= sgl_c;
        s1_multi  <= mul_c;
      end
    end
  end

  assign det_valid  = s1_valid;
  assign det_single = s1_valid && s1_single;
  assign det_multi  = s1_valid && s1_multi;

  edc_corrector #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_fix (
    .data   (s1_data),
    .syn    (s1_syn),
    .single (s1_single),
    .fixed  (fixed)
  );

  // Stage 2: correction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_check  <= '0;
      out_single <= 1'b0;
      out_multi  <= 1'b0;
    end else if (adv) begin
      out_valid  <= s1_valid;
      out_data   <= fixed;
      out_check  <= s1_check;
      out_single <= s1_valid && s1_single;
      out_multi  <= s1_valid && s1_multi;
    end
  end
endmodule

// File: rtl/edc_unit_chk.sv
module edc_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_write,
  input logic              det_valid,
  input logic              det_single,
  input logic              det_multi,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CHK_W-1:0]  out_check
);
  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> !(det_single && det_multi));

  p_write_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_write) |=> (det_valid && !det_single && !det_multi));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> det_valid);

  p_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && in_ready) |=> out_valid);

  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_check)));
endmodule

bind edc_unit edc_unit_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_write   (in_write),
  .det_valid  (det_valid),
  .det_single (det_single),
  .det_multi  (det_multi),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_check  (out_check)
);

// File: tb/tb_edc_unit.sv
`timescale 1ns/1ps
module tb_edc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_write = 1'b0, diag_en = 1'b0, out_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic [6:0]  in_check = '0, diag_check = '0;
  logic        in_ready, det_valid, det_single, det_multi;
  logic        out_valid, out_single, out_multi;
  logic [31:0] out_data;
  logic [6:0]  out_check;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edc_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_data(in_data), .in_check(in_check),
    .diag_en(diag_en), .diag_check(diag_check), .det_valid(det_valid),
    .det_single(det_single), .det_multi(det_multi), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_check(out_check),
    .out_single(out_single), .out_multi(out_multi)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check bits by XOR of the positions of set data bits
  function automatic logic [6:0] ref_chk(input logic [31:0] d);
    int acc = 0;
    int k = 0;
    for (int pos = 1; pos <= 38; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[k]) acc = acc ^ pos;
        k++;
      end
    end
    return {(^d) ^ (^acc[5:0]), acc[5:0]};
  endfunction

  // One request, out_ready high; flags checked at +1, data at +2
  task automatic xfer(input logic wr, input logic [31:0] d, input logic [6:0] c,
                      input logic de, input logic [6:0] dc, input string req,
                      input logic es, input logic em, input logic [31:0] ed,
                      input logic [6:0] ec);
    @(negedge clk);
    in_valid = 1'b1; in_write = wr; in_data = d; in_check = c;
    diag_en = de; diag_check = dc;
    @(negedge clk);
    in_valid = 1'b0;
    check(det_valid && det_single == es && det_multi == em, {req, " early flags"},
          {61'd0, det_valid, det_single, det_multi}, {61'd0, 1'b1, es, em});
    @(negedge clk);
    check(out_valid && out_single == es && out_multi == em && out_data == ed
          && out_check == ec, {req, " result"},
          {out_valid, out_single, out_multi, out_check, 22'd0, out_data},
          {1'b1, es, em, ec, 22'd0, ed});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] words [4];
    words[0] = 32'h0000_0000; words[1] = 32'hFFFF_FFFF;
    words[2] = 32'hA5A5_3C3C; words[3] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!det_valid && !out_valid && !det_single && !det_multi && !out_single
          && !out_multi && in_ready, "R11 reset", {59'd0, det_valid, out_valid,
          det_single, det_multi, in_ready}, 64'd1);
    rst_n = 1'b1;

    for (int w = 0; w < 4; w++) begin
      logic [31:0] d;
      logic [6:0]  c;
      logic [38:0] cw;
      d = words[w];
      c = ref_chk(d);
      // R1, R2: encode on write
      xfer(1'b1, d, 7'd0, 1'b0, 7'd0, "R1 R2 write", 1'b0, 1'b0, d, c);
      // R3: clean read
      xfer(1'b0, d, c, 1'b0, 7'd0, "R3 clean read", 1'b0, 1'b0, d, c);
      // R4, R5: every single flip
      for (int b = 0; b < 39; b++) begin
        cw = {c, d} ^ (39'd1 << b);
        if (b < 32) xfer(1'b0, cw[31:0], cw[38:32], 1'b0, 7'd0, "R4 data flip",
                         1'b1, 1'b0, d, cw[38:32]);
        else xfer(1'b0, cw[31:0], cw[38:32], 1'b0, 7'd0, "R5 check flip",
                  1'b1, 1'b0, d, cw[38:32]);
      end
      // R6: every double flip
      for (int a = 0; a < 39; a++) begin
        for (int b = a + 1; b < 39; b++) begin
          cw = {c, d} ^ (39'd1 << a) ^ (39'd1 << b);
          xfer(1'b0, cw[31:0], cw[38:32], 1'b0, 7'd0, "R6 double flip",
               1'b0, 1'b1, cw[31:0], cw[38:32]);
        end
      end
      // R7: data bit 0 (pos 3) with check bits 2 (pos 4) and 5 (pos 32): syndrome 39
      cw = {c, d} ^ 39'd1 ^ (39'd1 << 34) ^ (39'd1 << 37);
      xfer(1'b0, cw[31:0], cw[38:32], 1'b0, 7'd0, "R7 syndrome beyond range",
           1'b0, 1'b1, cw[31:0], cw[38:32]);
      // R10: override on write, ignored on read
      xfer(1'b1, d, 7'd0, 1'b1, c ^ 7'h05, "R10 diag write", 1'b0, 1'b0, d, c ^ 7'h05);
      xfer(1'b0, d, c, 1'b1, 7'h55, "R10 diag on read", 1'b0, 1'b0, d, c);
    end

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0; diag_en = 1'b0;
    in_valid = 1'b1; in_write = 1'b1; in_data = 32'h1111_1111;
    @(negedge clk);
    in_data = 32'h2222_2222;
    @(negedge clk);
    check(out_valid && out_data == 32'h1111_1111 && !in_ready && det_valid,
          "R9 stall first", {31'd0, in_ready, out_data}, {32'd0, 32'h1111_1111});
    in_data = 32'h3333_3333;
    repeat (2) @(negedge clk);
    check(out_valid && out_data == 32'h1111_1111 && out_check == ref_chk(32'h1111_1111)
          && !in_ready, "R9 held", {31'd0, in_ready, out_data}, {32'd0, 32'h1111_1111});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 32'h2222_2222, "R9 resume second",
          {32'd0, out_data}, {32'd0, 32'h2222_2222});
    @(negedge clk);
    check(out_valid && out_data == 32'h3333_3333, "R9 resume third",
          {32'd0, out_data}, {32'd0, 32'h3333_3333});
    @(negedge clk);
    check(!out_valid && !det_valid, "R8 drained", {62'd0, out_valid, det_valid}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule